// File: doc/BRIEF.md
# Panel Configuration Command Decoder

This block sits behind the host byte interface of a colour dot-matrix panel controller. Every byte arrives with a flag that marks it as pixel data or as a command. The block looks only at command bytes. It recognises opcodes that take no operand, one operand, two operands, or a 32-byte run, and it follows each sequence to its end. Each operand is written into the configuration register it belongs to. After the last operand, the next command byte is decoded as a new opcode.

All registers load their defaults on reset. They drive the display timing and the driver logic directly: display on/off, display mode, addressing and scan remap bits, colour format, start line, vertical offset, multiplex ratio, the column and row windows, three colour contrasts, and the master current code. The gray-scale pulse-width table stores only the 32 odd levels. Any of the 64 levels can be read through an index port: level 0 is zero, odd levels are read from storage, and even levels are the floor of the mean of their two odd neighbours.

Top module: `pcd_top`

## Requirements
- R1: After reset, the outputs hold these values: dispOn 0, dispMode 0, all remap bits 0, colorFmt 1, startLine 0, lineOffset 0, muxRatio 63, colStart 0, colEnd 95, rowStart 0, rowEnd 63, contrastA, contrastB and contrastC 0x80, masterCur 0xF.
- R2: A byte with isData high changes no output and does not advance a command sequence, even when it arrives in the middle of one.
- R3: Command 0xAF sets dispOn to 1 and 0xAE clears it. Commands 0xA4 to 0xA7 set dispMode to the opcode's low two bits: 0 normal, 1 all on, 2 all off, 3 inverse.
- R4: Commands 0x81, 0x82 and 0x83 load the next command byte into contrastA, contrastB and contrastC, in that order.
- R5: Command 0x87 loads bits 3:0 of the next byte into masterCur.
- R6: Command 0xA0 loads its operand as a remap byte: bit 0 into vertInc, bit 1 into colRev, bit 4 into comRev, bit 5 into comSplit, and bits 7:6 into colorFmt (0 = 8-bit colour, 1 = 16-bit colour).
- R7: Command 0xA1 loads bits 5:0 of its operand into startLine. Command 0xA2 loads bits 5:0 of its operand into lineOffset.
- R8: Command 0xA8 loads bits 5:0 of its operand into muxRatio. A value below 15 is stored as 15, so muxRatio is never below 15.
- R9: Command 0x15 loads two operands, bits 6:0 of each, into colStart and then colEnd. Command 0x75 loads two operands, bits 5:0 of each, into rowStart and then rowEnd.
- R10: Operand bytes are never decoded as opcodes, even when their values match an opcode. Command 0xB8 consumes exactly 32 operands, which become the widths of levels 1, 3, … 63 in that order.
- R11: gsWidth for gsIndex 0 is 0. For an odd index it is the stored width. For an even index n it is floor((W(n-1)+W(n+1))/2). The default odd widths are 4k+1 for odd level 2k+1.
- R12: Opcode 0xE3 and any unknown opcode change no output, and the following command byte is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A byte is presented this cycle |
| isData | input | 1 | 1 = pixel data byte, 0 = command byte |
| byteIn | input | 8 | Byte value |
| gsIndex | input | 6 | Gray level to look up |
| dispOn | output | 1 | Display enabled |
| dispMode | output | 2 | 0 normal, 1 all on, 2 all off, 3 inverse |
| vertInc | output | 1 | Vertical address increment |
| colRev | output | 1 | Column address reversal |
| comRev | output | 1 | Reverse common scan |
| comSplit | output | 1 | Odd/even common split |
| colorFmt | output | 2 | Pixel colour format |
| startLine | output | 6 | Display start line |
| lineOffset | output | 6 | Vertical offset |
| muxRatio | output | 6 | Multiplex ratio minus one |
| colStart | output | 7 | Column window start |
| colEnd | output | 7 | Column window end |
| rowStart | output | 6 | Row window start |
| rowEnd | output | 6 | Row window end |
| contrastA | output | 8 | Colour A contrast |
| contrastB | output | 8 | Colour B contrast |
| contrastC | output | 8 | Colour C contrast |
| masterCur | output | 4 | Master current code |
| gsWidth | output | 8 | Pulse width for gsIndex |

## Verification
The assertions assume that byteIn and isData are known in every cycle where byteValid is high. They also assume that the inputs hold defined values from the first clock while reset is asserted, because the source checks look one cycle back at the inputs. The bench drives every input to zero before reset is released and changes inputs only on the falling edge, holding byteValid high for a single cycle per byte. Each sequence is driven to completion, or is deliberately interrupted only by data bytes.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int GS_ODD = 32;                  // stored odd gray levels
  localparam int IDX_W  = $clog2(GS_ODD);      // operand index width
  localparam int CNT_W  = $clog2(GS_ODD + 1);  // remaining-operand counter
  localparam int LVL_W  = IDX_W + 1;           // full gray level index
  localparam int PW_W   = 8;                   // pulse width bits

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_ALL_ON  = 2'd1,
    MODE_ALL_OFF = 2'd2,
    MODE_INVERSE = 2'd3
  } disp_mode_e;

  // strobe from parser to register datapath
  typedef struct packed {
    logic             wrEn;
    logic [7:0]       op;
    logic [IDX_W-1:0] idx;
    logic [7:0]       data;
  } cfg_strobe_t;
endpackage

// File: rtl/pcd_parser.sv
module pcd_parser
  import pcd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        isData,
  input  logic [7:0]  byteIn,
  output cfg_strobe_t stb
);
  logic [7:0]       curOp;
  logic [CNT_W-1:0] left;
  logic [IDX_W-1:0] idx;

  function automatic logic [CNT_W-1:0] operandCount(input logic [7:0] op);
    case (op)
      8'h15, 8'h75:                                  operandCount = CNT_W'(2);
      8'h81, 8'h82, 8'h83, 8'h87,
      8'hA0, 8'hA1, 8'hA2, 8'hA8:                    operandCount = CNT_W'(1);
      8'hB8:                                         operandCount = CNT_W'(GS_ODD);
      default:                                       operandCount = '0;
    endcase
  endfunction

  function automatic logic isSingle(input logic [7:0] op);
    isSingle = (op[7:2] == 6'b101001) || (op[7:1] == 7'b1010111);
  endfunction

  logic cmdByte, busy;
  assign cmdByte = byteValid && !isData;
  assign busy    = (left != '0);

  always_comb begin
    stb = '0;
    if (cmdByte) begin
      if (busy) begin
        stb.wrEn = 1'b1;
        stb.op   = curOp;
        stb.idx  = idx;
        stb.data = byteIn;
      end else if (isSingle(byteIn)) begin
        stb.wrEn = 1'b1;
        stb.op   = byteIn;
        stb.data = byteIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      left  <= '0;
      curOp <= '0;
      idx   <= '0;
    end else if (cmdByte) begin
      if (busy) begin
        left <= left - CNT_W'(1);
        idx  <= idx + IDX_W'(1);
      end else begin
        left  <= operandCount(byteIn);
        curOp <= byteIn;
        idx   <= '0;
      end
    end
  end
endmodule

// File: rtl/pcd_regs.sv
module pcd_regs
  import pcd_pkg::*;
#(
  parameter int COL_W   = 7,
  parameter int ROW_W   = 6,
  parameter int COL_MAX = 95,
  parameter int MUX_MIN = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       stb,
  input  logic [LVL_W-1:0]  gsIndex,
  output logic              dispOn,
  output logic [1:0]        dispMode,
  output logic              vertInc,
  output logic              colRev,
  output logic              comRev,
  output logic              comSplit,
  output logic [1:0]        colorFmt,
  output logic [ROW_W-1:0]  startLine,
  output logic [ROW_W-1:0]  lineOffset,
  output logic [ROW_W-1:0]  muxRatio,
  output logic [COL_W-1:0]  colStart,
  output logic [COL_W-1:0]  colEnd,
  output logic [ROW_W-1:0]  rowStart,
  output logic [ROW_W-1:0]  rowEnd,
  output logic [7:0]        contrastA,
  output logic [7:0]        contrastB,
  output logic [7:0]        contrastC,
  output logic [3:0]        masterCur,
  output logic [PW_W-1:0]   gsWidth
);
  localparam logic [ROW_W-1:0] ROW_TOP = {ROW_W{1'b1}};

  logic [PW_W-1:0] oddPw [GS_ODD];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispOn     <= 1'b0;
      dispMode   <= MODE_NORMAL;
      vertInc    <= 1'b0;
      colRev     <= 1'b0;
      comRev     <= 1'b0;
      comSplit   <= 1'b0;
      colorFmt   <= 2'b01;
      startLine  <= '0;
      lineOffset <= '0;
      muxRatio   <= ROW_TOP;
      colStart   <= '0;
      colEnd     <= COL_W'(COL_MAX);
      rowStart   <= '0;
      rowEnd     <= ROW_TOP;
      contrastA  <= 8'h80;
      contrastB  <= 8'h80;
      contrastC  <= 8'h80;
      masterCur  <= 4'hF;
    end else if (stb.wrEn) begin
      case (stb.op)
        8'h15: if (stb.idx == '0) colStart <= stb.data[COL_W-1:0];
               else               colEnd   <= stb.data[COL_W-1:0];
        8'h75: if (stb.idx == '0) rowStart <= stb.data[ROW_W-1:0];
               else               rowEnd   <= stb.data[ROW_W-1:0];
        8'h81: contrastA <= stb.data;
        8'h82: contrastB <= stb.data;
        8'h83: contrastC <= stb.data;
        8'h87: masterCur <= stb.data[3:0];
        8'hA0: begin
          vertInc  <= stb.data[0];
          colRev   <= stb.data[1];
          comRev   <= stb.data[4];
          comSplit <= stb.data[5];
          colorFmt <= stb.data[7:6];
        end
        8'hA1: startLine  <= stb.data[ROW_W-1:0];
        8'hA2: lineOffset <= stb.data[ROW_W-1:0];
        8'hA8: muxRatio   <= (stb.data[ROW_W-1:0] < ROW_W'(MUX_MIN))
                             ? ROW_W'(MUX_MIN) : stb.data[ROW_W-1:0];
        8'hA4, 8'hA5, 8'hA6, 8'hA7: dispMode <= stb.op[1:0];
        8'hAE, 8'hAF: dispOn <= stb.op[0];
        default: ;
      endcase
    end
  end

  // odd-level pulse width storage
  for (genvar k = 0; k < GS_ODD; k++) begin : g_pw
    always_ff @(posedge clk) begin
      if (!rstN)
        oddPw[k] <= PW_W'(4 * k + 1);
      else if (stb.wrEn && stb.op == 8'hB8 && stb.idx == IDX_W'(k))
        oddPw[k] <= stb.data;
    end
  end

  // level lookup with even-level interpolation
  logic [IDX_W-1:0] upper, lower;
  logic [PW_W:0]    pairSum;
  assign upper   = gsIndex[LVL_W-1:1];
  assign lower   = upper - IDX_W'(1);
  assign pairSum = {1'b0, oddPw[lower]} + {1'b0, oddPw[upper]};

  always_comb begin
    if (gsIndex == '0)   gsWidth = '0;
    else if (gsIndex[0]) gsWidth = oddPw[upper];
    else                 gsWidth = pairSum[PW_W:1];
  end
endmodule

// File: rtl/pcd_top.sv
module pcd_top
  import pcd_pkg::*;
#(
  parameter int COL_W   = 7,
  parameter int ROW_W   = 6,
  parameter int COL_MAX = 95,
  parameter int MUX_MIN = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              isData,
  input  logic [7:0]        byteIn,
  input  logic [LVL_W-1:0]  gsIndex,
  output logic              dispOn,
  output logic [1:0]        dispMode,
  output logic              vertInc,
  output logic              colRev,
  output logic              comRev,
  output logic              comSplit,
  output logic [1:0]        colorFmt,
  output logic [ROW_W-1:0]  startLine,
  output logic [ROW_W-1:0]  lineOffset,
  output logic [ROW_W-1:0]  muxRatio,
  output logic [COL_W-1:0]  colStart,
  output logic [COL_W-1:0]  colEnd,
  output logic [ROW_W-1:0]  rowStart,
  output logic [ROW_W-1:0]  rowEnd,
  output logic [7:0]        contrastA,
  output logic [7:0]        contrastB,
  output logic [7:0]        contrastC,
  output logic [3:0]        masterCur,
  output logic [PW_W-1:0]   gsWidth
);
  cfg_strobe_t stb;

  pcd_parser u_ctl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .isData(isData),
    .byteIn(byteIn), .stb(stb)
  );

  pcd_regs #(.COL_W(COL_W), .ROW_W(ROW_W), .COL_MAX(COL_MAX), .MUX_MIN(MUX_MIN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .gsIndex(gsIndex),
    .dispOn(dispOn), .dispMode(dispMode), .vertInc(vertInc), .colRev(colRev),
    .comRev(comRev), .comSplit(comSplit), .colorFmt(colorFmt),
    .startLine(startLine), .lineOffset(lineOffset), .muxRatio(muxRatio),
    .colStart(colStart), .colEnd(colEnd), .rowStart(rowStart), .rowEnd(rowEnd),
    .contrastA(contrastA), .contrastB(contrastB), .contrastC(contrastC),
    .masterCur(masterCur), .gsWidth(gsWidth)
  );
endmodule

// File: rtl/pcd_checks.sv
module pcd_checks #(
  parameter int ROW_W   = 6,
  parameter int MUX_MIN = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             byteValid,
  input logic             isData,
  input logic [7:0]       byteIn,
  input logic             dispOn,
  input logic [1:0]       dispMode,
  input logic [ROW_W-1:0] muxRatio,
  input logic [7:0]       contrastA,
  input logic [3:0]       masterCur
);
  logic cmdIn;
  assign cmdIn = byteValid && !isData;

  AST_MUX_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    muxRatio >= ROW_W'(MUX_MIN)); // R8

  AST_ONOFF_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dispOn) |-> $past(cmdIn && byteIn[7:1] == 7'b1010111) && dispOn == $past(byteIn[0])); // R3

  AST_MODE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dispMode) |-> $past(cmdIn && byteIn[7:2] == 6'b101001) && dispMode == $past(byteIn[1:0])); // R3

  AST_CONTRAST_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(contrastA) |-> $past(cmdIn) && contrastA == $past(byteIn)); // R4

  AST_MASTER_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(masterCur) |-> $past(cmdIn) && masterCur == $past(byteIn[3:0])); // R5

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && isData) |=> $stable(dispOn) && $stable(dispMode) && $stable(contrastA) && $stable(muxRatio)); // R2
endmodule

bind pcd_top pcd_checks #(.ROW_W(ROW_W), .MUX_MIN(MUX_MIN)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .isData(isData), .byteIn(byteIn),
  .dispOn(dispOn), .dispMode(dispMode), .muxRatio(muxRatio),
  .contrastA(contrastA), .masterCur(masterCur)
);

// File: tb/pcd_top_test.sv
`timescale 1ns/1ps
module pcd_top_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 1'b0;
  logic isData = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic [5:0] gsIndex = 6'd0;
  logic dispOn, vertInc, colRev, comRev, comSplit;
  logic [1:0] dispMode, colorFmt;
  logic [5:0] startLine, lineOffset, muxRatio, rowStart, rowEnd;
  logic [6:0] colStart, colEnd;
  logic [7:0] contrastA, contrastB, contrastC, gsWidth;
  logic [3:0] masterCur;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pcd_top uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .isData(isData), .byteIn(byteIn),
    .gsIndex(gsIndex), .dispOn(dispOn), .dispMode(dispMode), .vertInc(vertInc),
    .colRev(colRev), .comRev(comRev), .comSplit(comSplit), .colorFmt(colorFmt),
    .startLine(startLine), .lineOffset(lineOffset), .muxRatio(muxRatio),
    .colStart(colStart), .colEnd(colEnd), .rowStart(rowStart), .rowEnd(rowEnd),
    .contrastA(contrastA), .contrastB(contrastB), .contrastC(contrastC),
    .masterCur(masterCur), .gsWidth(gsWidth)
  );

  task automatic check(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // one byte, one cycle; outputs settle on that rising edge, sampled at the next falling edge
  task automatic sendByte(input logic dataFlag, input logic [7:0] value);
    byteValid = 1'b1;
    isData    = dataFlag;
    byteIn    = value;
    @(negedge clk);
    byteValid = 1'b0;
    isData    = 1'b0;
    byteIn    = 8'h00;
  endtask

  task automatic cmd(input logic [7:0] value);
    sendByte(1'b0, value);
  endtask

  task automatic dat(input logic [7:0] value);
    sendByte(1'b1, value);
  endtask

  task automatic level(input int lvl, output int width);
    gsIndex = 6'(lvl);
    #1;
    width = int'(gsWidth);
  endtask

  task automatic testReset();
    int w;
    check("R1", "dispOn", dispOn, 0);
    check("R1", "dispMode", dispMode, 0);
    check("R1", "remap bits", {vertInc, colRev, comRev, comSplit}, 0);
    check("R1", "colorFmt", colorFmt, 1);
    check("R1", "startLine", startLine, 0);
    check("R1", "lineOffset", lineOffset, 0);
    check("R1", "muxRatio", muxRatio, 63);
    check("R1", "colStart", colStart, 0);
    check("R1", "colEnd", colEnd, 95);
    check("R1", "rowStart", rowStart, 0);
    check("R1", "rowEnd", rowEnd, 63);
    check("R1", "contrastA", contrastA, 128);
    check("R1", "contrastB", contrastB, 128);
    check("R1", "contrastC", contrastC, 128);
    check("R1", "masterCur", masterCur, 15);
    level(0, w);  check("R11", "default GS0", w, 0);
    level(1, w);  check("R11", "default GS1", w, 1);
    level(2, w);  check("R11", "default GS2", w, 3);
    level(62, w); check("R11", "default GS62", w, 123);
    level(63, w); check("R11", "default GS63", w, 125);
  endtask

  task automatic testContrast();
    cmd(8'h81); cmd(8'h12);
    check("R4", "contrastA", contrastA, 8'h12);
    cmd(8'h82); cmd(8'hAF);
    check("R4", "contrastB", contrastB, 8'hAF);
    check("R10", "operand 0xAF not decoded", dispOn, 0);
    cmd(8'h83); cmd(8'h00);
    check("R4", "contrastC", contrastC, 0);
    check("R4", "contrastA kept", contrastA, 8'h12);
  endtask

  task automatic testOnOffMode();
    cmd(8'hAF); check("R3", "display on", dispOn, 1);
    cmd(8'hA7); check("R3", "inverse mode", dispMode, 3);
    cmd(8'hA5); check("R3", "all on mode", dispMode, 1);
    cmd(8'hA6); check("R3", "all off mode", dispMode, 2);
    cmd(8'hA4); check("R3", "normal mode", dispMode, 0);
    cmd(8'hAE); check("R3", "display off", dispOn, 0);
  endtask

  task automatic testMaster();
    cmd(8'h87); cmd(8'hF3);
    check("R5", "masterCur low nibble", masterCur, 3);
  endtask

  task automatic testRemap();
    cmd(8'hA0); cmd(8'h33);
    check("R6", "remap fields", {vertInc, colRev, comRev, comSplit, colorFmt}, 6'b111100);
    cmd(8'hA0); cmd(8'h40);
    check("R6", "remap fields default", {vertInc, colRev, comRev, comSplit, colorFmt}, 6'b000001);
  endtask

  task automatic testLines();
    cmd(8'hA1); cmd(8'hFF);
    check("R7", "startLine", startLine, 63);
    cmd(8'hA2); cmd(8'h10);
    check("R7", "lineOffset", lineOffset, 16);
  endtask

  task automatic testMux();
    cmd(8'hA8); cmd(8'h05);
    check("R8", "mux clamp", muxRatio, 15);
    cmd(8'hA8); cmd(8'h20);
    check("R8", "mux 32", muxRatio, 32);
    cmd(8'hA8); cmd(8'h0F);
    check("R8", "mux at floor", muxRatio, 15);
  endtask

  task automatic testWindows();
    cmd(8'h15); cmd(8'h0A); cmd(8'h50);
    check("R9", "colStart", colStart, 10);
    check("R9", "colEnd", colEnd, 80);
    cmd(8'h75); cmd(8'h05); cmd(8'h30);
    check("R9", "rowStart", rowStart, 5);
    check("R9", "rowEnd", rowEnd, 48);
  endtask

  task automatic testDataIgnored();
    dat(8'hAF);
    check("R2", "data 0xAF ignored", dispOn, 0);
    cmd(8'h81);
    dat(8'h55);
    check("R2", "data mid-sequence", contrastA, 8'h12);
    cmd(8'h22);
    check("R2", "operand after data", contrastA, 8'h22);
  endtask

  task automatic testGray();
    int w;
    cmd(8'hB8);
    for (int k = 0; k < 32; k++) cmd(8'(7 * k + 1));
    level(0, w);  check("R11", "GS0", w, 0);
    level(1, w);  check("R10", "GS1", w, 1);
    level(2, w);  check("R11", "GS2 floor", w, 4);
    level(33, w); check("R10", "GS33", w, 113);
    level(63, w); check("R10", "GS63", w, 218);
    level(62, w); check("R11", "GS62", w, 214);
    cmd(8'hAF);
    check("R10", "sequence ends after 32", dispOn, 1);
    cmd(8'hAE);
  endtask

  task automatic testUnknown();
    cmd(8'h23); cmd(8'hAF);
    check("R12", "after unknown", dispOn, 1);
    cmd(8'hE3);
    check("R12", "nop keeps on", dispOn, 1);
    cmd(8'hA5);
    check("R12", "after nop", dispMode, 1);
    check("R12", "contrastA untouched", contrastA, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testContrast();
    testOnOffMode();
    testMaster();
    testRemap();
    testLines();
    testMux();
    testWindows();
    testDataIgnored();
    testGray();
    testUnknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule